// File: doc/BRIEF.md
# Voltage Regulator Fault Supervisor

This block watches the comparator flags of a two-phase voltage regulator and decides how the power stage reacts to each fault. It takes flags for overcurrent, severe overcurrent, absolute overvoltage, relative overvoltage, undervoltage, phase current imbalance and over-temperature. It also takes a flag that shows the output is below the release level, a regulator enable and a supply-valid input. From these it drives a tri-state request for each PWM output, a low-side force-on request, a power-good output and an active-low thermal warning.

Every fault class has its own qualification window. The window is given in microseconds and scaled by a cycles-per-microsecond parameter. A qualified fault sets a shutdown latch, which tri-states both phases and holds power-good low. An enable toggle or a supply cycle releases that latch. Absolute overvoltage follows a separate path. It clamps the output through the low-side switch until the output has fallen, and then it tri-states. Only a supply cycle releases it.

Top module: `vr_fault_supervisor`

## Requirements
- R1: Every flag, enable and supply-valid input passes through a two-flop synchronizer. An input change first affects the logic at the second rising edge after it.
- R2: Overcurrent that stays high for OC_US·CYC_PER_US consecutive synchronized cycles while armed sets the shutdown latch. While the latch is set, pwm1_tri_o and pwm2_tri_o are 1 and pgood_o is 0.
- R3: Severe overcurrent sets the shutdown latch after WOC_US·CYC_PER_US consecutive cycles. With the default of 1 µs this is under 2 µs.
- R4: Undervoltage, relative overvoltage and current imbalance each set the shutdown latch after SLOW_US·CYC_PER_US consecutive cycles. The default is 1 ms.
- R5: When a debounced flag drops before its window completes, the count for that flag restarts from zero.
- R6: Absolute overvoltage sets ls_force_o at the edge after its synchronized flag is seen. ls_force_o stays 1 until the synchronized below-release flag is seen. After that, both tri-state requests are 1 and pgood_o is 0.
- R7: The overvoltage state is released only while supply-valid is low. An enable toggle leaves it unchanged.
- R8: The shutdown latch clears on the rising edge of the synchronized enable, which always follows a fall. It also clears while supply-valid is low.
- R9: therm_n_o is the inverse of the synchronized over-temperature flag. Over-temperature has no effect on the tri-state requests or on pgood_o.
- R10: The debounced faults are armed only while both enable and supply-valid are high. Absolute overvoltage is armed whenever supply-valid is high, including while enable is low.
- R11: While ls_force_o is 1, both tri-state requests are 0, even when the shutdown latch is set.
- R12: pgood_o is 1 only when enable and supply-valid are high, the shutdown latch is clear and the overvoltage path is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_i | input | 1 | Overcurrent flag |
| woc_i | input | 1 | Severe overcurrent flag |
| ov_abs_i | input | 1 | Absolute overvoltage flag |
| ov_rel_i | input | 1 | Relative overvoltage flag |
| uv_i | input | 1 | Undervoltage flag |
| imb_i | input | 1 | Phase current imbalance flag |
| ot_i | input | 1 | Over-temperature flag |
| vout_low_i | input | 1 | Output below release level |
| en_i | input | 1 | Regulator enable |
| supply_ok_i | input | 1 | Supply valid |
| pwm1_tri_o | output | 1 | Tri-state request, phase 1 |
| pwm2_tri_o | output | 1 | Tri-state request, phase 2 |
| ls_force_o | output | 1 | Low-side force-on request |
| pgood_o | output | 1 | Power good |
| therm_n_o | output | 1 | Thermal warning, active low |

## Verification
Two functions can act in the same cycle: the overvoltage clamp and the tri-state shutdown. The bench provokes this in two ways. It raises absolute overvoltage while the shutdown latch is already set. It also raises severe overcurrent and absolute overvoltage together, so the two qualify within a few cycles of each other. A behavioural reference model, compared on every clock, must show ls_force_o high and both tri-state requests low while the clamp lasts, and the tri-state requests must return only after the below-release flag arrives. The bench also interleaves enable toggles and supply drops with both latches set, to show that each latch responds only to its own release condition.

// File: rtl/vr_fault_pkg.sv
package vr_fault_pkg;
  localparam int unsigned NFLAG = 10;
  localparam int unsigned I_OC    = 0;
  localparam int unsigned I_WOC   = 1;
  localparam int unsigned I_OVABS = 2;
  localparam int unsigned I_OVREL = 3;
  localparam int unsigned I_UV    = 4;
  localparam int unsigned I_IMB   = 5;
  localparam int unsigned I_OT    = 6;
  localparam int unsigned I_VLOW  = 7;
  localparam int unsigned I_EN    = 8;
  localparam int unsigned I_SUP   = 9;

  localparam int unsigned NDB = 5;

  typedef enum logic [1:0] {
    OV_IDLE  = 2'd0,
    OV_CLAMP = 2'd1,
    OV_TRIP  = 2'd2
  } ov_st_t;
endpackage

// File: rtl/vr_sync.sv
module vr_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/vr_debounce.sv
module vr_debounce #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  input  logic arm_i,
  output logic qual_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          live;

  assign live   = flag_i & arm_i;
  assign qual_o = live & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!live)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // R5
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $past(flag_i && arm_i));
endmodule

// File: rtl/vr_ov_ctrl.sv
module vr_ov_ctrl
  import vr_fault_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_i,
  input  logic ov_i,
  input  logic low_i,
  output logic clamp_o,
  output logic trip_o,
  output logic idle_o
);
  ov_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!sup_i) st_d = OV_IDLE;
    else begin
      unique case (st_q)
        OV_IDLE:  if (ov_i)  st_d = OV_CLAMP;
        OV_CLAMP: if (low_i) st_d = OV_TRIP;
        OV_TRIP:  st_d = OV_TRIP;
        default:  st_d = OV_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= OV_IDLE;
    else         st_q <= st_d;
  end

  assign clamp_o = (st_q == OV_CLAMP);
  assign trip_o  = (st_q == OV_TRIP);
  assign idle_o  = (st_q == OV_IDLE);

  // R7
  ov_trip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == OV_TRIP && sup_i) |=> (st_q == OV_TRIP));
  // R6
  ov_clamp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == OV_CLAMP && sup_i && !low_i) |=> (st_q == OV_CLAMP));
endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
  import vr_fault_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 50,
  parameter int unsigned OC_US      = 120,
  parameter int unsigned WOC_US     = 1,
  parameter int unsigned SLOW_US    = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic woc_i,
  input  logic ov_abs_i,
  input  logic ov_rel_i,
  input  logic uv_i,
  input  logic imb_i,
  input  logic ot_i,
  input  logic vout_low_i,
  input  logic en_i,
  input  logic supply_ok_i,
  output logic pwm1_tri_o,
  output logic pwm2_tri_o,
  output logic ls_force_o,
  output logic pgood_o,
  output logic therm_n_o
);
  localparam int unsigned OC_CYC   = OC_US * CYC_PER_US;
  localparam int unsigned WOC_CYC  = WOC_US * CYC_PER_US;
  localparam int unsigned SLOW_CYC = SLOW_US * CYC_PER_US;
  localparam int unsigned DB_LIM [NDB] = '{OC_CYC, WOC_CYC, SLOW_CYC, SLOW_CYC, SLOW_CYC};

  logic [NFLAG-1:0] raw, syn;
  logic [NDB-1:0]   db_flag, db_qual;
  logic armed, en_q, en_rise, shut_q;
  logic ov_clamp, ov_trip, ov_idle;

  assign raw = {supply_ok_i, en_i, vout_low_i, ot_i, imb_i, uv_i,
                ov_rel_i, ov_abs_i, woc_i, oc_i};

  vr_sync #(.W(NFLAG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign armed   = syn[I_EN] & syn[I_SUP];
  assign db_flag = {syn[I_IMB], syn[I_UV], syn[I_OVREL], syn[I_WOC], syn[I_OC]};

  for (genvar g = 0; g < NDB; g++) begin : g_db
    vr_debounce #(.LIMIT(DB_LIM[g])) u_db (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .flag_i(db_flag[g]),
      .arm_i (armed),
      .qual_o(db_qual[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= syn[I_EN];
  end
  assign en_rise = syn[I_EN] & ~en_q;

  // clear wins over set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               shut_q <= 1'b0;
    else if (!syn[I_SUP])      shut_q <= 1'b0;
    else if (en_rise)          shut_q <= 1'b0;
    else if (|db_qual)         shut_q <= 1'b1;
  end

  vr_ov_ctrl u_ov (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sup_i  (syn[I_SUP]),
    .ov_i   (syn[I_OVABS]),
    .low_i  (syn[I_VLOW]),
    .clamp_o(ov_clamp),
    .trip_o (ov_trip),
    .idle_o (ov_idle)
  );

  assign ls_force_o = ov_clamp;
  assign pwm1_tri_o = (shut_q | ov_trip) & ~ov_clamp;
  assign pwm2_tri_o = (shut_q | ov_trip) & ~ov_clamp;
  assign pgood_o    = armed & ~shut_q & ov_idle;
  assign therm_n_o  = ~syn[I_OT];

  // R8
  shut_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut_q && !en_rise && syn[I_SUP]) |=> shut_q);
  // R6
  clamp_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_force_o) |-> $past(syn[I_OVABS]));
  // R2
  shut_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shut_q) |-> $past(|db_qual));
endmodule

// File: tb/tb_vr_fault_supervisor.sv
module tb_vr_fault_supervisor;
  localparam int CPU = 2;
  localparam int L_OC = 120 * CPU, L_WOC = 1 * CPU, L_SLOW = 1000 * CPU;

  logic clk_i = 0, rst_ni = 0;
  logic oc_i = 0, woc_i = 0, ov_abs_i = 0, ov_rel_i = 0, uv_i = 0, imb_i = 0;
  logic ot_i = 0, vout_low_i = 0, en_i = 0, supply_ok_i = 0;
  logic pwm1_tri_o, pwm2_tri_o, ls_force_o, pgood_o, therm_n_o;

  vr_fault_supervisor #(.CYC_PER_US(CPU)) dut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R12";

  // reference model: synchronizer pipeline as two-deep history, run lengths as integers
  bit s1 [10], s2 [10];
  int run [5];
  int lim [5] = '{L_OC, L_WOC, L_SLOW, L_SLOW, L_SLOW};
  bit m_shut, m_en_prev;
  int m_ov; // 0 idle, 1 clamp, 2 trip

  function automatic bit rawv(int i);
    case (i)
      0: return oc_i; 1: return woc_i; 2: return ov_abs_i; 3: return ov_rel_i;
      4: return uv_i; 5: return imb_i; 6: return ot_i; 7: return vout_low_i;
      8: return en_i; default: return supply_ok_i;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (s1[i]) begin s1[i] = 0; s2[i] = 0; end
      foreach (run[i]) run[i] = 0;
      m_shut = 0; m_en_prev = 0; m_ov = 0;
    end else begin
      bit armed, rise, q;
      int dbi [5];
      dbi = '{0, 1, 3, 4, 5};
      armed = s2[8] && s2[9];
      rise = s2[8] && !m_en_prev;
      q = 0;
      for (int k = 0; k < 5; k++) begin
        if (s2[dbi[k]] && armed) run[k]++; else run[k] = 0;
        if (run[k] >= lim[k]) q = 1;
      end
      if (!s2[9] || rise) m_shut = 0; else if (q) m_shut = 1;
      if (!s2[9]) m_ov = 0;
      else if (m_ov == 0 && s2[2]) m_ov = 1;
      else if (m_ov == 1 && s2[7]) m_ov = 2;
      m_en_prev = s2[8];
      for (int i = 0; i < 10; i++) begin s2[i] = s1[i]; s1[i] = rawv(i); end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    bit e_ls, e_tri, e_pg, e_th;
    e_ls  = (m_ov == 1);
    e_tri = (m_shut || m_ov == 2) && !e_ls;
    e_pg  = s2[8] && s2[9] && !m_shut && m_ov == 0;
    e_th  = !s2[6];
    chk(ls_force_o == e_ls, cur_req, "ls_force", ls_force_o, e_ls);
    chk(pwm1_tri_o == e_tri && pwm2_tri_o == e_tri, cur_req, "pwm_tri",
        {pwm1_tri_o, pwm2_tri_o}, {e_tri, e_tri});
    chk(pgood_o == e_pg, cur_req, "pgood", pgood_o, e_pg);
    chk(therm_n_o == e_th, cur_req, "therm_n", therm_n_o, e_th);
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic toggle_en();
    en_i = 0; wait_n(4); en_i = 1; wait_n(4);
  endtask

  task automatic sup_cycle();
    supply_ok_i = 0; wait_n(4); supply_ok_i = 1; wait_n(4);
  endtask

  task automatic run_main();
    wait_n(2);
    // reset state: nothing enabled
    chk(pgood_o == 0 && ls_force_o == 0 && pwm1_tri_o == 0, "R12", "reset", pgood_o, 0);
    chk(therm_n_o == 1, "R9", "reset therm", therm_n_o, 1);
    rst_ni = 1;
    supply_ok_i = 1; en_i = 1;
    cur_req = "R1";
    wait_n(1);
    chk(pgood_o == 0, "R1", "pgood one edge after enable", pgood_o, 0);
    wait_n(2);
    chk(pgood_o == 1, "R12", "pgood up", pgood_o, 1);

    cur_req = "R5";
    oc_i = 1; wait_n(L_OC - 10); oc_i = 0; wait_n(5);
    oc_i = 1; wait_n(L_OC - 10); oc_i = 0; wait_n(5);
    chk(pwm1_tri_o == 0 && pgood_o == 1, "R5", "oc restart", pwm1_tri_o, 0);
    cur_req = "R2";
    oc_i = 1; wait_n(L_OC + 4); oc_i = 0; wait_n(4);
    chk(pwm1_tri_o == 1 && pwm2_tri_o == 1 && pgood_o == 0, "R2", "oc latch", pwm1_tri_o, 1);
    cur_req = "R8";
    toggle_en();
    chk(pwm1_tri_o == 0 && pgood_o == 1, "R8", "enable clears", pwm1_tri_o, 0);

    cur_req = "R3";
    woc_i = 1; wait_n(1); woc_i = 0; wait_n(4);
    chk(pwm1_tri_o == 0, "R3", "woc short", pwm1_tri_o, 0);
    woc_i = 1; wait_n(L_WOC + 3); woc_i = 0; wait_n(3);
    chk(pwm1_tri_o == 1, "R3", "woc latch", pwm1_tri_o, 1);
    cur_req = "R8";
    sup_cycle();
    chk(pwm1_tri_o == 0 && pgood_o == 1, "R8", "supply clears", pwm1_tri_o, 0);

    cur_req = "R4";
    uv_i = 1; wait_n(L_SLOW - 20);
    chk(pwm1_tri_o == 0, "R4", "uv early", pwm1_tri_o, 0);
    wait_n(25); uv_i = 0; wait_n(3);
    chk(pwm1_tri_o == 1, "R4", "uv latch", pwm1_tri_o, 1);
    toggle_en();
    ov_rel_i = 1; wait_n(L_SLOW + 4); ov_rel_i = 0; wait_n(3);
    chk(pgood_o == 0, "R4", "ovrel latch", pgood_o, 0);
    toggle_en();
    imb_i = 1; wait_n(L_SLOW + 4); imb_i = 0; wait_n(3);
    chk(pwm2_tri_o == 1, "R4", "imb latch", pwm2_tri_o, 1);
    toggle_en();

    cur_req = "R9";
    ot_i = 1; wait_n(3);
    chk(therm_n_o == 0 && pgood_o == 1 && pwm1_tri_o == 0, "R9", "ot", therm_n_o, 0);
    ot_i = 0; wait_n(3);

    cur_req = "R10";
    en_i = 0; wait_n(3);
    oc_i = 1; wait_n(L_OC + 10); oc_i = 0;
    en_i = 1; wait_n(4);
    chk(pwm1_tri_o == 0 && pgood_o == 1, "R10", "oc ignored disabled", pwm1_tri_o, 0);
    en_i = 0; wait_n(3);
    ov_abs_i = 1; wait_n(3);
    chk(ls_force_o == 1, "R10", "ov armed while disabled", ls_force_o, 1);
    cur_req = "R6";
    ov_abs_i = 0; wait_n(10);
    chk(ls_force_o == 1 && pwm1_tri_o == 0, "R6", "clamp held", ls_force_o, 1);
    vout_low_i = 1; wait_n(3);
    chk(ls_force_o == 0 && pwm1_tri_o == 1, "R6", "trip after release", pwm1_tri_o, 1);
    vout_low_i = 0;
    cur_req = "R7";
    en_i = 1; wait_n(4); toggle_en();
    chk(pwm1_tri_o == 1 && pgood_o == 0, "R7", "enable keeps ov", pwm1_tri_o, 1);
    sup_cycle();
    chk(pwm1_tri_o == 0 && pgood_o == 1, "R7", "supply clears ov", pgood_o, 1);

    cur_req = "R11";
    oc_i = 1; wait_n(L_OC + 4); oc_i = 0; wait_n(2);
    ov_abs_i = 1; wait_n(3); ov_abs_i = 0;
    chk(ls_force_o == 1 && pwm1_tri_o == 0, "R11", "clamp over latch", pwm1_tri_o, 0);
    sup_cycle();
    woc_i = 1; ov_abs_i = 1; wait_n(L_WOC + 4); woc_i = 0; ov_abs_i = 0; wait_n(2);
    chk(ls_force_o == 1 && pwm2_tri_o == 0, "R11", "same cycle", pwm2_tri_o, 0);
    vout_low_i = 1; wait_n(3); vout_low_i = 0;
    chk(pwm2_tri_o == 1, "R11", "tri after clamp", pwm2_tri_o, 1);
    sup_cycle();
    wait_n(5);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule